// File: doc/BRIEF.md
# I2C Target Interface with Clock Stretching

This block lets a host processor act as an addressed target on a two-wire I2C bus. It takes in the bus clock and data lines and samples them on the system clock. It recognises start and stop conditions and compares the first byte of each transfer with a 7-bit station address. The block drives the bus only through pull-low enables, which suits open-drain pads.

In the write direction, each completed byte goes into a single receive buffer. A full flag and an overflow flag guard that buffer. The block acknowledges a byte only when the buffer has room. In the read direction, the host loads a byte into a transmit buffer, which also loads the output shift register, and the block shifts it out MSB first.

Between bytes the block can hold the clock line low until the host gives a release pulse. It always does this after a read-address match and after every read byte that the controller acknowledges. In the write direction it does this only when stretching is enabled. A per-byte interrupt flag tells the host when to service the interface. A direction bit tells the host which way the current transfer runs.

Top module: `i2c_tgt_stretch`

## Requirements
- R1: A start is a falling SDA while SCL is high, and a stop is a rising SDA while SCL is high. A start always restarts address reception, even after an ignored transfer. After a stop, neither bus line is driven.
- R2: When an address byte {address[6:0], direction bit 0} matches `own_addr` and the buffer has room, the block drives SDA low during the ninth clock. It loads the whole 8-bit address byte into the receive buffer and clears `rw_stat`.
- R3: When the 7-bit address does not match, the block sends no ACK and does not change the buffer. It raises no interrupt. All later bytes are ignored until the next start.
- R4: Write data bytes are received MSB first. Each one is placed in `rx_data` with `rx_full` set, and is ACKed when the buffer has room.
- R5: When a byte completes while `rx_full` or `rx_ovf` is set, the byte is NACKed and `rx_data` keeps its value. When `rx_full` was set at that moment, `rx_ovf` is also set. This applies to both address bytes and data bytes.
- R6: `irq` is set at the falling edge of the ninth clock of every byte of an addressed transfer, whether the byte was ACKed or NACKed. It stays set until `irq_clr`.
- R7: With `stretch_en` high, SCL is held low after the ninth clock of every write-direction byte, including the address byte. It stays low until a `scl_rel` pulse. With `stretch_en` low, no write byte is stretched.
- R8: When an address byte with direction bit 1 matches and is ACKed, `rw_stat` is set and the address byte is loaded into the buffer. SCL is then held low whatever the value of `stretch_en`.
- R9: A `tx_wr` pulse loads the output shift register. Read bits go out MSB first and change only while SCL is low, so SDA is steady while SCL is high.
- R10: The controller's ACK/NACK is sampled on the ninth rising edge of a read byte. On ACK, SCL is held low again until `scl_rel`. On NACK, `rw_stat` clears, both lines are released and the block waits for a start.
- R11: A `rx_rd` pulse clears `rx_full`, and a `ovf_clr` pulse clears `rx_ovf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| scl_oe | output | 1 | Pulls the bus clock low when high (stretch) |
| sda_oe | output | 1 | Pulls the bus data line low when high |
| own_addr | input | 7 | Station address of this target |
| stretch_en | input | 1 | Stretch after every write-direction byte |
| scl_rel | input | 1 | Host pulse that releases a held clock |
| tx_data | input | 8 | Byte for the next read transfer |
| tx_wr | input | 1 | Loads `tx_data` into the output shift register |
| rx_data | output | 8 | Receive buffer |
| rx_rd | input | 1 | Host pulse: buffer has been read |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| rx_ovf | output | 1 | A byte arrived while the buffer was full |
| ovf_clr | input | 1 | Clears the overflow flag |
| irq | output | 1 | Per-byte service flag |
| irq_clr | input | 1 | Clears the service flag |
| rw_stat | output | 1 | Direction of the current transfer, 1 for read |

## Verification
The bit counter and the state register have no direct outputs. If either is wrong, the ACK appears on the wrong clock or is missing. Either fault shows on `sda_oe` within one byte time, or the stretch on `scl_oe` starts late or never starts. A wrong shift register shows as a wrong byte in `rx_data` at the eighth falling edge, or as a wrong bit read back by the controller. A flag that fails to stick or to clear shows as an ACK/NACK mismatch on the very next byte.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 7;
    localparam int CNT_W  = $clog2(DATA_W + 1);

    localparam logic [CNT_W-1:0] CNT_BYTE = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_A,
        ST_WR_DATA,
        ST_ACK_W,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_IGNORE
    } tgt_state_e;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } rx_evt_t;

    function automatic logic addr_hit(input logic [DATA_W-1:0] b,
                                      input logic [ADDR_W-1:0] a);
        return b[DATA_W-1 -: ADDR_W] == a;
    endfunction

endpackage

// File: rtl/i2c_line_mon.sv
module i2c_line_mon #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    localparam int NL = 2;

    logic [NL-1:0] pins;
    logic [NL-1:0] synced;
    logic [NL-1:0] prev;

    assign pins = {sda_i, scl_i};

    for (genvar g = 0; g < NL; g++) begin : g_sync
        logic [SYNC_N-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[SYNC_N-2:0], pins[g]};
        end
        assign synced[g] = chain[SYNC_N-1];
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= synced;
    end

    assign scl_s     = synced[0];
    assign sda_s     = synced[1];
    assign scl_rise  =  synced[0] & ~prev[0];
    assign scl_fall  = ~synced[0] &  prev[0];
    assign start_evt =  synced[0] & prev[0] &  prev[1] & ~synced[1];
    assign stop_evt  =  synced[0] & prev[0] & ~prev[1] &  synced[1];

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              stretch_en,
    input  logic              scl_rel,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_full,
    input  logic              rx_ovf,
    output rx_evt_t           byte_evt,
    output logic              irq_evt,
    output logic              rw_stat,
    output logic              sda_drv,
    output logic              scl_hold
);
    tgt_state_e        st;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] tx_sh;
    logic              addr_acked;
    logic              m_nack;
    logic              room;
    logic              byte_in;

    assign room    = !(rx_full || rx_ovf);
    assign byte_in = scl_fall && (cnt == CNT_BYTE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            cnt        <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            addr_acked <= 1'b0;
            m_nack     <= 1'b0;
            rw_stat    <= 1'b0;
            sda_drv    <= 1'b0;
            scl_hold   <= 1'b0;
            byte_evt   <= '0;
            irq_evt    <= 1'b0;
        end else begin
            byte_evt.valid <= 1'b0;
            irq_evt        <= 1'b0;

            if (tx_wr) begin
                tx_sh <= tx_data;
                if (scl_hold && st == ST_RD_DATA) sda_drv <= ~tx_data[DATA_W-1];
            end
            if (scl_rel) scl_hold <= 1'b0;

            if (stop_evt) begin
                st      <= ST_IDLE;
                sda_drv <= 1'b0;
            end else if (start_evt) begin
                st      <= ST_ADDR;
                cnt     <= '0;
                sda_drv <= 1'b0;
            end else begin
                unique case (st)
                    ST_ADDR, ST_WR_DATA: begin
                        if (scl_rise) begin
                            rx_sh <= {rx_sh[DATA_W-2:0], sda_s};
                            cnt   <= cnt + 1'b1;
                        end else if (byte_in) begin
                            if (st == ST_ADDR && !addr_hit(rx_sh, own_addr)) begin
                                st <= ST_IGNORE;
                            end else begin
                                byte_evt.valid <= 1'b1;
                                byte_evt.data  <= rx_sh;
                                sda_drv        <= room;
                                if (st == ST_ADDR) begin
                                    addr_acked <= room;
                                    if (room) rw_stat <= rx_sh[0];
                                    st <= ST_ACK_A;
                                end else begin
                                    st <= ST_ACK_W;
                                end
                            end
                        end
                    end
                    ST_ACK_A: begin
                        if (scl_fall) begin
                            irq_evt <= 1'b1;
                            cnt     <= '0;
                            if (!addr_acked) begin
                                sda_drv <= 1'b0;
                                st      <= ST_IGNORE;
                            end else if (rw_stat) begin
                                sda_drv  <= ~tx_sh[DATA_W-1];
                                scl_hold <= 1'b1;
                                st       <= ST_RD_DATA;
                            end else begin
                                sda_drv  <= 1'b0;
                                scl_hold <= stretch_en;
                                st       <= ST_WR_DATA;
                            end
                        end
                    end
                    ST_ACK_W: begin
                        if (scl_fall) begin
                            irq_evt  <= 1'b1;
                            cnt      <= '0;
                            sda_drv  <= 1'b0;
                            scl_hold <= stretch_en;
                            st       <= ST_WR_DATA;
                        end
                    end
                    ST_RD_DATA: begin
                        if (scl_fall) begin
                            if (cnt == CNT_LAST) begin
                                sda_drv <= 1'b0;
                                st      <= ST_RD_ACK;
                            end else begin
                                tx_sh   <= {tx_sh[DATA_W-2:0], 1'b0};
                                sda_drv <= ~tx_sh[DATA_W-2];
                                cnt     <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            m_nack <= sda_s;
                        end else if (scl_fall) begin
                            irq_evt <= 1'b1;
                            cnt     <= '0;
                            if (m_nack) begin
                                rw_stat <= 1'b0;
                                st      <= ST_IDLE;
                            end else begin
                                sda_drv  <= ~tx_sh[DATA_W-1];
                                scl_hold <= 1'b1;
                                st       <= ST_RD_DATA;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    p_sda_steady_r9: assert property (@(posedge clk) disable iff (rst)
        (scl_s && $past(scl_s)) |-> $stable(sda_drv));

    p_hold_till_rel_r7: assert property (@(posedge clk) disable iff (rst)
        (scl_hold && !scl_rel) |=> scl_hold);

    p_ack_needs_room_r5: assert property (@(posedge clk) disable iff (rst)
        ($rose(sda_drv) && (st == ST_ACK_A || st == ST_ACK_W))
            |-> ($past(!rx_full) && $past(!rx_ovf)));

    p_read_addr_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RD_DATA && $past(st) == ST_ACK_A) |-> scl_hold);

endmodule

// File: rtl/i2c_tgt_rxbuf.sv
module i2c_tgt_rxbuf
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  rx_evt_t           byte_evt,
    input  logic              irq_evt,
    input  logic              rx_rd,
    input  logic              ovf_clr,
    input  logic              irq_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              rx_ovf,
    output logic              irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data <= '0;
            rx_full <= 1'b0;
            rx_ovf  <= 1'b0;
            irq     <= 1'b0;
        end else begin
            if (byte_evt.valid && !rx_full && !rx_ovf) begin
                rx_data <= byte_evt.data;
                rx_full <= 1'b1;
            end else if (rx_rd) begin
                rx_full <= 1'b0;
            end

            if (byte_evt.valid && rx_full) rx_ovf <= 1'b1;
            else if (ovf_clr)              rx_ovf <= 1'b0;

            if (irq_evt)      irq <= 1'b1;
            else if (irq_clr) irq <= 1'b0;
        end
    end

    p_ovf_cause_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_ovf) |-> $past(rx_full));

    p_keep_data_r5: assert property (@(posedge clk) disable iff (rst)
        rx_full |=> $stable(rx_data));

    p_irq_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq);

endmodule

// File: rtl/i2c_tgt_stretch.sv
module i2c_tgt_stretch
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              stretch_en,
    input  logic              scl_rel,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_wr,
    output logic [DATA_W-1:0] rx_data,
    input  logic              rx_rd,
    output logic              rx_full,
    output logic              rx_ovf,
    input  logic              ovf_clr,
    output logic              irq,
    input  logic              irq_clr,
    output logic              rw_stat
);
    logic    scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    rx_evt_t byte_evt;
    logic    irq_evt;

    i2c_line_mon #(.SYNC_N(SYNC_N)) u_mon (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    i2c_tgt_engine u_eng (
        .clk        (clk),
        .rst        (rst),
        .scl_s      (scl_s),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_evt  (start_evt),
        .stop_evt   (stop_evt),
        .own_addr   (own_addr),
        .stretch_en (stretch_en),
        .scl_rel    (scl_rel),
        .tx_wr      (tx_wr),
        .tx_data    (tx_data),
        .rx_full    (rx_full),
        .rx_ovf     (rx_ovf),
        .byte_evt   (byte_evt),
        .irq_evt    (irq_evt),
        .rw_stat    (rw_stat),
        .sda_drv    (sda_oe),
        .scl_hold   (scl_oe)
    );

    i2c_tgt_rxbuf u_buf (
        .clk      (clk),
        .rst      (rst),
        .byte_evt (byte_evt),
        .irq_evt  (irq_evt),
        .rx_rd    (rx_rd),
        .ovf_clr  (ovf_clr),
        .irq_clr  (irq_clr),
        .rx_data  (rx_data),
        .rx_full  (rx_full),
        .rx_ovf   (rx_ovf),
        .irq      (irq)
    );

endmodule

// File: tb/sim_i2c_tgt_stretch.sv
module sim_i2c_tgt_stretch;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;
    localparam int WD_CYCLES  = 150000;
    localparam logic [6:0] OWN = 7'h3A;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl_low = 1'b0, m_sda_low = 1'b0;
    logic       scl_i, sda_i, scl_oe, sda_oe;
    logic       stretch_en = 1'b0, scl_rel = 1'b0, tx_wr = 1'b0;
    logic [7:0] tx_data = '0;
    logic [7:0] rx_data;
    logic       rx_rd = 1'b0, rx_full, rx_ovf, ovf_clr = 1'b0;
    logic       irq, irq_clr = 1'b0, rw_stat;

    int  n_chk = 0, n_fail = 0;
    bit  mf = 0, mo = 0;
    logic [7:0] md = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign scl_i = ~(m_scl_low | scl_oe);
    assign sda_i = ~(m_sda_low | sda_oe);

    i2c_tgt_stretch u0 (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(OWN),
        .stretch_en(stretch_en), .scl_rel(scl_rel), .tx_data(tx_data),
        .tx_wr(tx_wr), .rx_data(rx_data), .rx_rd(rx_rd), .rx_full(rx_full),
        .rx_ovf(rx_ovf), .ovf_clr(ovf_clr), .irq(irq), .irq_clr(irq_clr),
        .rw_stat(rw_stat)
    );

    function automatic logic [7:0] f_abyte(input logic [6:0] a, input bit rw);
        return {a, rw};
    endfunction

    function automatic bit f_room(input bit full, input bit ovf);
        return !full && !ovf;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        while (!scl_i) @(negedge clk);
    endtask

    task automatic pulse_rd();   rx_rd = 1;   cyc(1); rx_rd = 0;   cyc(1); mf = 0; endtask
    task automatic pulse_ovf();  ovf_clr = 1; cyc(1); ovf_clr = 0; cyc(1); mo = 0; endtask
    task automatic pulse_irq();  irq_clr = 1; cyc(1); irq_clr = 0; cyc(1); endtask
    task automatic pulse_rel();  scl_rel = 1; cyc(1); scl_rel = 0; cyc(2); endtask
    task automatic load_tx(input logic [7:0] v);
        tx_data = v; tx_wr = 1; cyc(1); tx_wr = 0; cyc(1);
    endtask

    task automatic model_byte(input logic [7:0] v);
        if (mf)       mo = 1;
        else if (!mo) begin md = v; mf = 1; end
    endtask

    task automatic m_start();
        if (!scl_i) begin
            m_sda_low = 0; cyc(Q);
            m_scl_low = 0; wait_scl_high(); cyc(Q);
        end
        m_sda_low = 1; cyc(Q);
        m_scl_low = 1; cyc(Q);
    endtask

    task automatic m_stop();
        m_sda_low = 1; cyc(Q);
        m_scl_low = 0; wait_scl_high(); cyc(Q);
        m_sda_low = 0; cyc(Q);
    endtask

    task automatic m_wbyte(input logic [7:0] v, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda_low = !v[i]; cyc(Q);
            m_scl_low = 0; wait_scl_high(); cyc(Q);
            m_scl_low = 1;
        end
        m_sda_low = 0; cyc(Q);
        m_scl_low = 0; wait_scl_high(); cyc(Q/2);
        ack = !sda_i; cyc(Q/2);
        m_scl_low = 1; cyc(Q);
    endtask

    task automatic m_rbyte(input bit m_ack, output logic [7:0] v, output bit steady);
        logic s1, s2;
        steady = 1;
        m_sda_low = 0;
        for (int i = 7; i >= 0; i--) begin
            cyc(Q);
            m_scl_low = 0; wait_scl_high(); cyc(2);
            s1 = sda_i; cyc(Q);
            s2 = sda_i;
            if (s1 !== s2) steady = 0;
            v[i] = s1;
            m_scl_low = 1;
        end
        cyc(Q);
        m_sda_low = m_ack;
        m_scl_low = 0; wait_scl_high(); cyc(Q);
        m_scl_low = 1; cyc(Q);
        m_sda_low = 0;
    endtask

    bit done = 0;

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", WD_CYCLES, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit ack, steady;
        logic [7:0] v, ab;
        void'($urandom(32'd20240611));
        cyc(5); rst = 0; cyc(5);

        // reset state
        chk("R1 reset scl_oe", scl_oe, 0);
        chk("R1 reset sda_oe", sda_oe, 0);
        chk("R6 reset irq", irq, 0);
        chk("R11 reset full", rx_full, 0);
        chk("R11 reset ovf", rx_ovf, 0);
        chk("R2 reset rw", rw_stat, 0);

        // directed write, no stretch
        m_start();
        ab = f_abyte(OWN, 0); model_byte(ab);
        m_wbyte(ab, ack);
        chk("R2 addr ack", ack, 1);
        chk("R2 rw clear", rw_stat, 0);
        chk("R2 addr in buffer", rx_data, ab);
        chk("R6 irq on addr", irq, 1);
        cyc(30);
        chk("R6 irq sticky", irq, 1);
        pulse_irq();
        chk("R6 irq cleared", irq, 0);
        pulse_rd();
        chk("R11 rd clears full", rx_full, 0);
        m_wbyte(8'hA5, ack); model_byte(8'hA5);
        chk("R4 data ack", ack, 1);
        chk("R4 data value", rx_data, 8'hA5);
        chk("R4 full set", rx_full, 1);
        chk("R7 no stretch when off", scl_oe, 0);
        m_wbyte(8'h3C, ack); model_byte(8'h3C);
        chk("R5 nack when full", ack, 0);
        chk("R5 ovf set", rx_ovf, 1);
        chk("R5 data kept", rx_data, 8'hA5);
        pulse_rd();
        m_wbyte(8'h77, ack); model_byte(8'h77);
        chk("R5 nack when ovf", ack, 0);
        chk("R5 data kept ovf", rx_data, 8'hA5);
        chk("R5 not full", rx_full, 0);
        pulse_ovf();
        chk("R11 ovf cleared", rx_ovf, 0);
        m_wbyte(8'h0F, ack); model_byte(8'h0F);
        chk("R4 ack after clear", ack, 1);
        chk("R4 data after clear", rx_data, 8'h0F);
        m_stop();
        chk("R1 stop releases scl", scl_oe, 0);
        chk("R1 stop releases sda", sda_oe, 0);
        pulse_rd(); pulse_irq();

        // address mismatch
        m_start();
        m_wbyte(f_abyte(OWN ^ 7'h01, 0), ack);
        chk("R3 mismatch nack", ack, 0);
        chk("R3 mismatch no irq", irq, 0);
        chk("R3 mismatch no load", rx_full, 0);
        m_wbyte(f_abyte(OWN, 0), ack);
        chk("R3 ignored byte nack", ack, 0);
        chk("R3 ignored byte no load", rx_full, 0);
        m_start();
        m_wbyte(f_abyte(OWN, 0), ack); model_byte(f_abyte(OWN, 0));
        chk("R1 repeated start re-arms", ack, 1);
        m_stop(); pulse_rd(); pulse_irq();

        // write stretching
        stretch_en = 1;
        m_start();
        m_wbyte(f_abyte(OWN, 0), ack);
        chk("R7 addr ack", ack, 1);
        chk("R7 stretch after addr", scl_oe, 1);
        cyc(40);
        chk("R7 still held", scl_i, 0);
        pulse_rel();
        chk("R7 released", scl_oe, 0);
        pulse_rd(); pulse_irq();
        m_wbyte(8'h81, ack);
        chk("R7 stretch after data", scl_oe, 1);
        chk("R4 stretched data", rx_data, 8'h81);
        pulse_rel(); pulse_rd(); pulse_irq();
        m_stop();
        stretch_en = 0;

        // read transfer
        m_start();
        ab = f_abyte(OWN, 1);
        m_wbyte(ab, ack);
        chk("R8 read addr ack", ack, 1);
        chk("R8 rw set", rw_stat, 1);
        chk("R8 held regardless", scl_oe, 1);
        chk("R8 addr in buffer", rx_data, ab);
        pulse_rd(); pulse_irq();
        load_tx(8'hC3); pulse_rel();
        m_rbyte(1, v, steady);
        chk("R9 read byte", v, 8'hC3);
        chk("R9 sda steady", steady, 1);
        chk("R6 irq after read byte", irq, 1);
        chk("R10 held after ack", scl_oe, 1);
        pulse_irq();
        load_tx(8'h5A); pulse_rel();
        m_rbyte(0, v, steady);
        chk("R9 second read byte", v, 8'h5A);
        chk("R10 nack clears rw", rw_stat, 0);
        chk("R10 nack frees scl", scl_oe, 0);
        chk("R10 nack frees sda", sda_oe, 0);
        m_stop(); pulse_irq();

        // random transfers
        mf = 0; mo = 0;
        for (int t = 0; t < 30; t++) begin
            bit match, rw, se, exp_ack;
            int nb;
            logic [6:0] a;
            match = ($urandom % 4) != 0;
            rw    = $urandom % 2;
            se    = $urandom % 2;
            stretch_en = se;
            a  = match ? OWN : (OWN ^ 7'(1 + $urandom % 127));
            ab = f_abyte(a, rw);
            exp_ack = match && f_room(mf, mo);
            if (match) model_byte(ab);
            m_start();
            m_wbyte(ab, ack);
            chk("R2 R3 rand addr ack", ack, exp_ack);
            chk("R6 rand addr irq", irq, match);
            chk("R5 rand buffer", rx_data, md);
            chk("R5 rand ovf", rx_ovf, mo);
            pulse_irq();
            if (!exp_ack) begin
                m_wbyte(8'($urandom), ack);
                chk("R3 rand ignored", ack, 0);
                chk("R3 rand no irq", irq, 0);
            end else if (!rw) begin
                chk("R7 rand addr stretch", scl_oe, se);
                if (se) pulse_rel();
                nb = 1 + $urandom % 3;
                for (int k = 0; k < nb; k++) begin
                    if ($urandom % 2) pulse_rd();
                    v = 8'($urandom);
                    exp_ack = f_room(mf, mo);
                    model_byte(v);
                    m_wbyte(v, ack);
                    chk("R4 R5 rand data ack", ack, exp_ack);
                    chk("R4 rand data", rx_data, md);
                    chk("R4 rand full", rx_full, mf);
                    chk("R5 rand ovf", rx_ovf, mo);
                    chk("R7 rand data stretch", scl_oe, se);
                    if (se) pulse_rel();
                    pulse_irq();
                end
            end else begin
                chk("R8 rand rw", rw_stat, 1);
                chk("R8 rand hold", scl_oe, 1);
                nb = 1 + $urandom % 3;
                for (int k = 0; k < nb; k++) begin
                    logic [7:0] tv;
                    tv = 8'($urandom);
                    load_tx(tv); pulse_rel();
                    m_rbyte(k != nb - 1, v, steady);
                    chk("R9 rand read", v, tv);
                    chk("R9 rand steady", steady, 1);
                    chk("R10 rand hold", scl_oe, k != nb - 1);
                    pulse_irq();
                end
                chk("R10 rand rw cleared", rw_stat, 0);
            end
            m_stop();
            chk("R1 rand stop sda", sda_oe, 0);
            chk("R1 rand stop scl", scl_oe, 0);
            if ($urandom % 2) pulse_rd();
            if ($urandom % 2) pulse_ovf();
            chk("R11 rand full", rx_full, mf);
            chk("R11 rand ovf", rx_ovf, mo);
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule